// File: doc/BRIEF.md
# Programmable Logic Slice

This block models one programmable logic slice as it would sit inside an array of configurable fabric. The slice has two identical halves. Each half has a 16-entry look-up table driven by four address inputs. A configuration word selects how each table behaves: as a fixed truth table, as a small RAM that is written synchronously and read asynchronously, or as an addressable shift register. Beside each table sits a hardwired carry stage, so two halves form a two-bit slice of a ripple adder. Each half also has a storage element that can be set up as a flip-flop or a latch, with optional inversion of its input and a programmable set/reset.

The configuration is loaded serially through a single data pin while a load enable is held high. Loading never disturbs the storage elements. A dedicated multiplexer steers one of the two table outputs to a wide-function output, so the two tables together can realise any 5-input function. Carry out of the upper half leaves the slice so that slices can be chained into wider adders.

Top module: `logic_slice`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into a 46-bit chain. After 46 edges, the first bit sent holds table 0 entry 0. Table 0 occupies chain bits 0 to 15, table 1 occupies bits 16 to 31, and the control word occupies bits 32 to 45. `cfg_dout` always shows table 0 entry 0.
- R2: The control field of half h starts at chain bit 32+7h and has these bits: [1:0] mode (00 table, 01 RAM, 10 shift, 11 table), [2] latch select, [3] asynchronous set/reset, [4] set value, [5] invert storage input, [6] select sum for `comb_o`. When bit [6] is 0, `comb_o[h]` equals the table entry addressed by that half's four inputs.
- R3: `wide_o` equals the table 1 output when `wsel` is 1 and the table 0 output when `wsel` is 0.
- R4: In RAM mode, a rising edge with `ce` high writes `din[h]` into the addressed entry, and the read path shows it at once without a clock. With `ce` low the entry is left unchanged. Written entries are the same bits as the configuration, so they appear on `cfg_dout`.
- R5: In shift mode, a rising edge with `ce` high moves `din[h]` into entry 0 and moves every entry up by one. The address selects the tap. With `ce` low the contents hold.
- R6: Each half computes propagate as address bit 0 XOR address bit 1. Its carry out is the incoming carry when propagate is 1, and address bit 1 when propagate is 0. Half 0 takes `cin`, half 1 takes the carry of half 0, and `cout` is the carry of half 1.
- R7: When control bit [6] is 1, `comb_o[h]` equals the half's propagate XOR its incoming carry. Two slices chained through `cout`/`cin` therefore add two 4-bit operands exactly.
- R8: With the latch select clear, the storage element loads `comb_o[h]` (inverted when bit [5] is set) on a rising edge when `ce` is high. Otherwise it holds its value.
- R9: With the latch select set, the storage element follows its input while `clk` is high and `ce` is high, and holds it while `clk` is low.
- R10: `sr` forces the storage element to the set value. In synchronous mode this happens at the next rising edge regardless of `ce`. In asynchronous mode it happens immediately.
- R11: A low `rst_n` at a rising edge clears the configuration chain and the flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| cfg_dout | output | 1 | End of the configuration chain |
| a0 | input | 4 | Address inputs of half 0 |
| a1 | input | 4 | Address inputs of half 1 |
| cin | input | 1 | Carry into half 0 |
| wsel | input | 1 | Wide-function select |
| ce | input | 1 | Clock enable for tables and storage |
| sr | input | 1 | Set/reset request |
| din | input | 2 | Write/shift data per half |
| comb_o | output | 2 | Combinational output per half |
| wide_o | output | 1 | Wide multiplexer output |
| reg_o | output | 2 | Storage element output per half |
| cout | output | 1 | Carry out of half 1 |

## Verification
The bench adds all 512 combinations of two 4-bit operands and a carry through two chained slices. A carry multiplexer with its legs swapped, or a sum that skips the incoming carry, gives wrong totals for a subset of these combinations. Clock-enable gating is checked in every writable mode: a RAM write, a shift or a flip-flop load taken with `ce` low shows up as a changed table entry or register. The set/reset tests probe the output between edges, so a synchronous reset that acts early or an asynchronous one that waits for the clock is exposed. The latch test changes the input while the clock is high and again while it is low, which catches a latch that behaves like a flip-flop or stays transparent all the time.

// File: rtl/slice_pkg.sv
// Shared sizes and configuration types for the logic slice.
// Assumes exactly two halves per slice; the table depth follows LUT_K.
package slice_pkg;
    localparam int LUT_K         = 4;
    localparam int LUT_DEPTH     = 1 << LUT_K;
    localparam int HALVES        = 2;
    localparam int CTRL_PER_HALF = 7;
    localparam int CTRL_W        = HALVES * CTRL_PER_HALF;
    localparam int CFG_W         = HALVES * LUT_DEPTH + CTRL_W;

    typedef enum logic [1:0] {
        MODE_TABLE = 2'b00,
        MODE_RAM   = 2'b01,
        MODE_SHIFT = 2'b10,
        MODE_ALT   = 2'b11
    } lut_mode_e;

    typedef struct packed {
        logic      src_sum;
        logic      inv_d;
        logic      sr_set;
        logic      sr_async;
        logic      latch;
        lut_mode_e mode;
    } half_ctrl_t;
endpackage

// File: rtl/slice_lut.sv
// One look-up table with its own segment of the serial configuration chain.
// The same bits serve as truth table, RAM contents or shift register.
// Assumes cfg_en has priority over functional writes.
module slice_lut
    import slice_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_sin,
    input  lut_mode_e       mode,
    input  logic            ce,
    input  logic            wdata,
    input  logic [K-1:0]    addr,
    output logic            lut_o,
    output logic            cfg_sout
);
    localparam int DEPTH = 1 << K;

    logic [DEPTH-1:0] tbl;

    // Update table bits: config shift, RAM write or shift-register advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else if (cfg_en) begin
            tbl <= {cfg_sin, tbl[DEPTH-1:1]};
        end else if (ce) begin
            case (mode)
                MODE_RAM:   tbl[addr] <= wdata;
                MODE_SHIFT: tbl <= {tbl[DEPTH-2:0], wdata};
                default:    ;
            endcase
        end
    end

    assign lut_o    = tbl[addr];
    assign cfg_sout = tbl[0];
endmodule

// File: rtl/slice_store.sv
// Configurable storage element: flip-flop or level latch, optional input
// inversion, set/reset that is synchronous or asynchronous.
// Assumes both storage styles run in parallel and the output picks one.
module slice_store
    import slice_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  half_ctrl_t ctl,
    input  logic       ce,
    input  logic       sr,
    input  logic       d_in,
    output logic       q
);
    logic d_eff;
    logic arst;
    logic ff_q;
    logic lat_q;

    assign d_eff = d_in ^ ctl.inv_d;
    assign arst  = sr & ctl.sr_async;

    // Edge-triggered storage with async set/reset override.
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            ff_q <= ctl.sr_set;
        end else if (!rst_n) begin
            ff_q <= 1'b0;
        end else if (sr) begin
            ff_q <= ctl.sr_set;
        end else if (ce) begin
            ff_q <= d_eff;
        end
    end

    // Level-sensitive storage, transparent while the clock is high.
    always_latch begin
        if (arst) begin
            lat_q = ctl.sr_set;
        end else if (clk) begin
            if (!rst_n) begin
                lat_q = 1'b0;
            end else if (sr) begin
                lat_q = ctl.sr_set;
            end else if (ce) begin
                lat_q = d_eff;
            end
        end
    end

    assign q = ctl.latch ? lat_q : ff_q;
endmodule

// File: rtl/logic_slice.sv
// Two-half programmable logic slice: tables, carry chain, wide multiplexer
// and storage. The configuration enters at cfg_din, passes the control
// register, then table 1, then table 0, and leaves at cfg_dout.
// Assumes HALVES is 2, matching the per-half ports.
module logic_slice
    import slice_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic         cfg_dout,
    input  logic [K-1:0] a0,
    input  logic [K-1:0] a1,
    input  logic         cin,
    input  logic         wsel,
    input  logic         ce,
    input  logic         sr,
    input  logic [1:0]   din,
    output logic [1:0]   comb_o,
    output logic         wide_o,
    output logic [1:0]   reg_o,
    output logic         cout
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [HALVES:0]   chain;
    logic [HALVES:0]   cy;
    logic [HALVES-1:0] lut_o;
    logic [K-1:0]      addr [HALVES];

    assign addr[0] = a0;
    assign addr[1] = a1;

    // Control segment of the serial configuration chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_en) begin
            ctrl_q <= {cfg_din, ctrl_q[CTRL_W-1:1]};
        end
    end

    assign chain[HALVES] = ctrl_q[0];
    assign cfg_dout      = chain[0];
    assign cy[0]         = cin;
    assign cout          = cy[HALVES];

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            half_ctrl_t hc;
            logic       prop;
            logic       sum;

            assign hc   = half_ctrl_t'(ctrl_q[h*CTRL_PER_HALF +: CTRL_PER_HALF]);
            assign prop = addr[h][0] ^ addr[h][1];
            assign sum  = prop ^ cy[h];
            assign cy[h+1] = prop ? cy[h] : addr[h][1];
            assign comb_o[h] = hc.src_sum ? sum : lut_o[h];

            slice_lut #(.K(K)) u_lut (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_en   (cfg_en),
                .cfg_sin  (chain[h+1]),
                .mode     (hc.mode),
                .ce       (ce),
                .wdata    (din[h]),
                .addr     (addr[h]),
                .lut_o    (lut_o[h]),
                .cfg_sout (chain[h])
            );

            slice_store u_store (
                .clk   (clk),
                .rst_n (rst_n),
                .ctl   (hc),
                .ce    (ce),
                .sr    (sr),
                .d_in  (comb_o[h]),
                .q     (reg_o[h])
            );
        end
    endgenerate

    assign wide_o = wsel ? lut_o[1] : lut_o[0];
endmodule

// File: rtl/logic_slice_checker.sv
// Assertions on carry behaviour and storage control of logic_slice.
// Assumes ctrl is the slice's control register, observed through a bind.
module logic_slice_checker
    import slice_pkg::*;
#(
    parameter int K = LUT_K
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [K-1:0]      a0,
    input logic [K-1:0]      a1,
    input logic              cin,
    input logic              ce,
    input logic              sr,
    input logic [1:0]        reg_o,
    input logic              cout,
    input logic [CTRL_W-1:0] ctrl
);
    // R6: both halves propagating passes the input carry straight through
    a_r6_carry_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((a0[0] != a0[1]) && (a1[0] != a1[1])) |-> (cout == cin));

    // R6: an upper half that does not propagate drives its own carry
    a_r6_carry_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (a1[0] == a1[1]) |-> (cout == a1[1]));

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_chk
            logic is_latch;
            logic is_async;
            logic set_val;
            assign is_latch = ctrl[h*CTRL_PER_HALF + 2];
            assign is_async = ctrl[h*CTRL_PER_HALF + 3];
            assign set_val  = ctrl[h*CTRL_PER_HALF + 4];

            // R8: a flip-flop with clock enable low keeps its value
            a_r8_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_en && !ce && !sr && !is_latch)
                |=> (sr || (reg_o[h] == $past(reg_o[h]))));

            // R10: an asynchronous set/reset holds the output at the set value
            a_r10_async_force: assert property (@(posedge clk) disable iff (!rst_n)
                (sr && is_async) |-> (reg_o[h] == set_val));
        end
    endgenerate
endmodule

bind logic_slice logic_slice_checker #(.K(K)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .a0     (a0),
    .a1     (a1),
    .cin    (cin),
    .ce     (ce),
    .sr     (sr),
    .reg_o  (reg_o),
    .cout   (cout),
    .ctrl   (ctrl_q)
);

// File: tb/logic_slice_test.sv
module logic_slice_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] a0 = '0, a1 = '0, h0 = '0, h1 = '0;
    logic       cin = 1'b0, wsel = 1'b0, ce = 1'b0, sr = 1'b0;
    logic [1:0] din = '0;
    logic       cfg_dout, cfg_dout_hi, wide_o, wide_hi, cout, cout_hi;
    logic [1:0] comb_o, comb_hi, reg_o, reg_hi;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    logic_slice uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
        .a0(a0), .a1(a1), .cin(cin), .wsel(wsel), .ce(ce), .sr(sr), .din(din),
        .comb_o(comb_o), .wide_o(wide_o), .reg_o(reg_o), .cout(cout)
    );
    logic_slice uut_hi (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout_hi),
        .a0(h0), .a1(h1), .cin(cout), .wsel(wsel), .ce(ce), .sr(sr), .din(din),
        .comb_o(comb_hi), .wide_o(wide_hi), .reg_o(reg_hi), .cout(cout_hi)
    );

    // table-mode vectors: {a0, a1, wsel, exp comb0, exp comb1, exp wide}
    // with table 0 = 16'hA5C3 and table 1 = 16'h0F0F
    localparam logic [11:0] VEC [10] = '{
        {4'd0,  4'd0,  1'b0, 3'b111}, {4'd2,  4'd5,  1'b1, 3'b000},
        {4'd6,  4'd9,  1'b1, 3'b111}, {4'd9,  4'd12, 1'b0, 3'b000},
        {4'd15, 4'd3,  1'b1, 3'b111}, {4'd13, 4'd4,  1'b0, 3'b101},
        {4'd4,  4'd8,  1'b1, 3'b011}, {4'd11, 4'd14, 1'b0, 3'b000},
        {4'd10, 4'd7,  1'b1, 3'b100}, {4'd7,  4'd2,  1'b0, 3'b111}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] hcf(input logic [1:0] m, input logic lat, input logic as_,
                                       input logic st, input logic inv, input logic src);
        return {src, inv, st, as_, lat, m};
    endfunction

    task automatic load(input logic [15:0] t0, input logic [15:0] t1, input logic [13:0] c);
        logic [45:0] v;
        v  = {c, t1, t0};
        ce = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 46; i++) begin
            cfg_en  = 1'b1;
            cfg_din = v[i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 reset reg", {6'd0, reg_o}, 8'd0);
        check("R11 reset comb", {6'd0, comb_o}, 8'd0);
        check("R6 reset cout", {7'd0, cout}, 8'd0);
        rst_n = 1'b1;

        // R1 R2 R3: table mode walk
        load(16'hA5C3, 16'h0F0F, 14'd0);
        for (int i = 0; i < 10; i++) begin
            a0 = VEC[i][11:8]; a1 = VEC[i][7:4]; wsel = VEC[i][3];
            #1;
            check("R2 comb0", {7'd0, comb_o[0]}, {7'd0, VEC[i][2]});
            check("R2 comb1", {7'd0, comb_o[1]}, {7'd0, VEC[i][1]});
            check("R3 wide", {7'd0, wide_o}, {7'd0, VEC[i][0]});
        end
        check("R1 cfg_dout", {7'd0, cfg_dout}, 8'd1);

        // R7 R6: exhaustive 4-bit add over two slices
        load(16'h0, 16'h0, {7'h40, 7'h40});
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    a0 = {2'b0, 1'(y), 1'(x)};
                    a1 = {2'b0, 1'(y >> 1), 1'(x >> 1)};
                    h0 = {2'b0, 1'(y >> 2), 1'(x >> 2)};
                    h1 = {2'b0, 1'(y >> 3), 1'(x >> 3)};
                    cin = 1'(c);
                    #1;
                    check("R7 R6 add", {3'd0, cout_hi, comb_hi, comb_o}, 8'(x + y + c));
                end
            end
        end
        cin = 1'b0;

        // R4: RAM mode in half 0
        load(16'h0, 16'h0, {7'h00, hcf(2'b01, 0, 0, 0, 0, 0)});
        a0 = 4'd5; din = 2'b01; ce = 1'b1;
        @(negedge clk);
        check("R4 ram write", {7'd0, comb_o[0]}, 8'd1);
        a0 = 4'd4; #1;
        check("R4 ram other", {7'd0, comb_o[0]}, 8'd0);
        ce = 1'b0; a0 = 4'd6;
        @(negedge clk);
        check("R4 ram ce low", {7'd0, comb_o[0]}, 8'd0);
        a0 = 4'd0; ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        check("R4 ram on chain", {7'd0, cfg_dout}, 8'd1);

        // R5: shift mode in half 0, feed 1,0,1,1
        load(16'h0, 16'h0, {7'h00, hcf(2'b10, 0, 0, 0, 0, 0)});
        ce = 1'b1;
        din = 2'b01; @(negedge clk);
        din = 2'b00; @(negedge clk);
        din = 2'b01; @(negedge clk);
        din = 2'b01; @(negedge clk);
        ce = 1'b0; din = 2'b00;
        @(negedge clk);
        for (int t = 0; t < 5; t++) begin
            a0 = 4'(t); #1;
            check("R5 shift tap", {7'd0, comb_o[0]}, (t == 0 || t == 1 || t == 3) ? 8'd1 : 8'd0);
        end

        // R8: flip-flop load, hold, inversion
        load(16'h00FF, 16'h0, {7'h00, hcf(2'b00, 0, 0, 0, 0, 0)});
        a0 = 4'd0; ce = 1'b1;
        @(negedge clk);
        check("R8 ff load", {6'd0, reg_o}, 8'd1);
        a0 = 4'd8; ce = 1'b0;
        @(negedge clk);
        check("R8 ff hold", {7'd0, reg_o[0]}, 8'd1);
        ce = 1'b1;
        @(negedge clk);
        check("R8 ff load 0", {7'd0, reg_o[0]}, 8'd0);
        load(16'h00FF, 16'h0, {7'h00, hcf(2'b00, 0, 0, 0, 1, 0)});
        a0 = 4'd8; ce = 1'b1;
        @(negedge clk);
        check("R8 ff invert", {7'd0, reg_o[0]}, 8'd1);

        // R10: synchronous reset waits for the edge, ignores ce
        load(16'h00FF, 16'h0, {7'h00, hcf(2'b00, 0, 0, 0, 0, 0)});
        a0 = 4'd0; ce = 1'b1;
        @(negedge clk);
        ce = 1'b0; sr = 1'b1;
        #2;
        check("R10 sync before edge", {7'd0, reg_o[0]}, 8'd1);
        @(negedge clk);
        check("R10 sync after edge", {7'd0, reg_o[0]}, 8'd0);
        sr = 1'b0;

        // R10: asynchronous reset acts at once
        load(16'h00FF, 16'h0, {7'h00, hcf(2'b00, 0, 1, 0, 0, 0)});
        a0 = 4'd0; ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        #1; sr = 1'b1; #1;
        check("R10 async clear", {7'd0, reg_o[0]}, 8'd0);
        @(negedge clk);
        sr = 1'b0;
        load(16'h00FF, 16'h0, {7'h00, hcf(2'b00, 0, 1, 1, 0, 0)});
        a0 = 4'd8; ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        check("R10 async pre", {7'd0, reg_o[0]}, 8'd0);
        #1; sr = 1'b1; #1;
        check("R10 async set", {7'd0, reg_o[0]}, 8'd1);
        @(negedge clk);
        sr = 1'b0;

        // R9: latch transparent while clk high, holding while low
        load(16'h00FF, 16'h0, {7'h00, hcf(2'b00, 1, 0, 0, 0, 0)});
        a0 = 4'd0; ce = 1'b1;
        @(posedge clk); #1;
        check("R9 latch open", {7'd0, reg_o[0]}, 8'd1);
        #1; a0 = 4'd8; #1;
        check("R9 latch follows", {7'd0, reg_o[0]}, 8'd0);
        @(negedge clk); #1;
        a0 = 4'd0; #1;
        check("R9 latch holds", {7'd0, reg_o[0]}, 8'd0);
        @(posedge clk); #1;
        check("R9 latch reopens", {7'd0, reg_o[0]}, 8'd1);
        @(negedge clk);
        ce = 1'b0;

        // R11: reset clears loaded configuration
        load(16'hFFFF, 16'h0, 14'd0);
        a0 = 4'd3; #1;
        check("R2 all ones", {7'd0, comb_o[0]}, 8'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 config cleared", {7'd0, comb_o[0]}, 8'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule